// File: doc/BRIEF.md
# Serial Transmit Suspension Controller

This block sits between a transmit FIFO and one serial audio transmitter channel and brings streaming to an orderly stop. While idle it passes FIFO words to the serializer untouched. When the stop request input rises, it loads a live counter from a programmed block count. Each block-complete pulse then lowers that counter by one while FIFO data keeps flowing.

Once the count is used up, the next block boundary puts the block into a suspension state. In that state the serializer receives a fixed substitute word held in a register, and the FIFO is no longer read. When the stop request is withdrawn, the block leaves suspension at the following block boundary and FIFO traffic resumes.

Two registers can be reached through a simple write and read port: the block count and the substitute word. Reads of the block count return the live counter value.

Top module: `txsusp_ctrl`

## Requirements
- R1: After hardware reset both registers read as zero, `suspended` is low and `txData` follows `fifoData`.
- R2: Register address 0 selects the block count and address 1 selects the substitute word. `regRdData` shows the selected register in the same cycle. A write to the block count while idle loads both the programmed value and the live counter, so it reads back at once.
- R3: A rising edge of `stopReq` loads the live counter from the programmed count. Each `blockDone` pulse while draining with a nonzero counter lowers it by one.
- R4: A `blockDone` pulse while draining with the live counter at zero enters suspension. With a programmed count N, suspension therefore starts at the (N+1)th pulse after the stop request, and `suspended` is high from the next cycle.
- R5: With a programmed count of zero, the first `blockDone` pulse after the stop request enters suspension.
- R6: While suspended, `txData` equals the substitute word and `fifoReady` is low. Otherwise `txData` equals `fifoData` and `fifoReady` equals `txTake`.
- R7: Once `stopReq` is low while suspended, the block returns to idle at the next `blockDone` pulse, and not before.
- R8: Dropping `stopReq` while draining returns the block to idle in the next cycle. The live counter keeps its value.
- R9: A write to the substitute word while `dmaEn` is high is ignored, and the register keeps its old value.
- R10: `dmaRst` clears only the substitute word. `swRst` clears the substitute word and both counters and returns the block to idle.
- R11: A write to the block count while draining or suspended changes only the programmed value. The live counter continues undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low |
| swRst | input | 1 | Software reset of the block |
| dmaRst | input | 1 | DMA-controller software reset; clears the substitute word |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 block count, 1 substitute word |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the selected register |
| stopReq | input | 1 | Stop request level |
| dmaEn | input | 1 | Channel DMA enable; blocks substitute-word writes |
| blockDone | input | 1 | One-cycle block-complete pulse |
| txTake | input | 1 | Serializer takes a word this cycle |
| fifoData | input | 32 | FIFO head word |
| fifoValid | input | 1 | FIFO head word is valid |
| fifoReady | output | 1 | FIFO pop strobe |
| txData | output | 32 | Word offered to the serializer |
| txValid | output | 1 | `txData` is valid |
| suspended | output | 1 | High while in the suspension state |

## Verification
The hardest state to reach from the ports is a register write that arrives in the middle of a drain. The live counter is visible only through the read port, so the bench must prove that the write did not touch it. To get there, the stimulus raises the stop request with a small count, lets one block boundary pass, and then writes a different count. It then reads the counter and counts the remaining boundaries up to suspension. A behavioural model runs alongside every cycle and also sees randomized stop, block and write traffic. That traffic includes stop requests withdrawn during the drain and during suspension.

// File: rtl/txsusp_pkg.sv
package txsusp_pkg;
  parameter int DATA_W = 32;
  parameter int CNT_W  = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_SUSP  = 2'd2
  } suspState_e;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic cntFree;
    logic suspOn;
  } ctrlStrobe_t;
endpackage

// File: rtl/txsusp_datapath.sv
module txsusp_datapath
  import txsusp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          swRst,
  input  logic          dmaRst,
  input  logic          regWrEn,
  input  logic          regAddr,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  input  logic          dmaEn,
  input  logic          txTake,
  input  logic [DW-1:0] fifoData,
  input  logic          fifoValid,
  output logic          fifoReady,
  output logic [DW-1:0] txData,
  output logic          txValid,
  input  ctrlStrobe_t   strobe,
  output logic          cntZero
);
  localparam int RD_PAD = (DW > CW) ? DW - CW : 0;

  logic [CW-1:0] progCnt;
  logic [CW-1:0] liveCnt;
  logic [DW-1:0] subWord;
  logic          wrCnt;
  logic          wrSub;

  assign wrCnt = regWrEn && !regAddr;
  assign wrSub = regWrEn && regAddr && !dmaEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progCnt <= '0;
      liveCnt <= '0;
    end else if (swRst) begin
      progCnt <= '0;
      liveCnt <= '0;
    end else begin
      if (wrCnt) progCnt <= regWrData[CW-1:0];
      if (strobe.loadCnt)                 liveCnt <= progCnt;
      else if (strobe.decCnt)             liveCnt <= liveCnt - 1'b1;
      else if (wrCnt && strobe.cntFree)   liveCnt <= regWrData[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                subWord <= '0;
    else if (swRst || dmaRst) subWord <= '0;
    else if (wrSub)           subWord <= regWrData;
  end

  assign cntZero   = (liveCnt == '0);
  generate
    if (RD_PAD > 0) begin : g_padRd
      assign regRdData = regAddr ? subWord : {{RD_PAD{1'b0}}, liveCnt};
    end else begin : g_fullRd
      assign regRdData = regAddr ? subWord : liveCnt[DW-1:0];
    end
  endgenerate
  assign txData    = strobe.suspOn ? subWord : fifoData;
  assign txValid   = strobe.suspOn ? 1'b1 : fifoValid;
  assign fifoReady = txTake && !strobe.suspOn;

  // R9
  sub_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(subWord) |-> $past(!dmaEn || swRst || dmaRst));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt < $past(liveCnt)) |->
      (liveCnt == $past(liveCnt) - 1'b1) || $past(swRst) || $past(wrCnt) || $past(strobe.loadCnt));
endmodule

// File: rtl/txsusp_control.sv
module txsusp_control
  import txsusp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swRst,
  input  logic        stopReq,
  input  logic        blockDone,
  input  logic        cntZero,
  output ctrlStrobe_t strobe
);
  suspState_e state, stateNext;
  logic       stopReqQ;
  logic       stopRise;

  assign stopRise = stopReq && !stopReqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stopReqQ <= 1'b0;
    else       stopReqQ <= stopReq;
  end

  always_comb begin
    stateNext      = state;
    strobe.loadCnt = 1'b0;
    strobe.decCnt  = 1'b0;
    unique case (state)
      ST_IDLE: if (stopRise) begin
        stateNext      = ST_DRAIN;
        strobe.loadCnt = 1'b1;
      end
      ST_DRAIN: begin
        if (!stopReq)        stateNext = ST_IDLE;
        else if (blockDone) begin
          if (cntZero)       stateNext = ST_SUSP;
          else               strobe.decCnt = 1'b1;
        end
      end
      ST_SUSP: if (blockDone && !stopReq) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
    if (swRst) begin
      stateNext      = ST_IDLE;
      strobe.loadCnt = 1'b0;
      strobe.decCnt  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strobe.cntFree = (state == ST_IDLE);
  assign strobe.suspOn  = (state == ST_SUSP);

  // R4
  susp_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.suspOn) |-> $past(blockDone && cntZero && stopReq));

  // R7
  susp_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.suspOn) |-> $past((blockDone && !stopReq) || swRst));

  // R8
  drain_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && !stopReq && !swRst) |=> (state == ST_IDLE));
endmodule

// File: rtl/txsusp_ctrl.sv
module txsusp_ctrl
  import txsusp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swRst,
  input  logic        dmaRst,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        stopReq,
  input  logic        dmaEn,
  input  logic        blockDone,
  input  logic        txTake,
  input  logic [31:0] fifoData,
  input  logic        fifoValid,
  output logic        fifoReady,
  output logic [31:0] txData,
  output logic        txValid,
  output logic        suspended
);
  ctrlStrobe_t strobe;
  logic        cntZero;

  txsusp_control u_ctrl (
    .clk(clk), .rstN(rstN), .swRst(swRst), .stopReq(stopReq),
    .blockDone(blockDone), .cntZero(cntZero), .strobe(strobe)
  );

  txsusp_datapath #(.DW(32), .CW(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .swRst(swRst), .dmaRst(dmaRst),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .dmaEn(dmaEn), .txTake(txTake),
    .fifoData(fifoData), .fifoValid(fifoValid), .fifoReady(fifoReady),
    .txData(txData), .txValid(txValid), .strobe(strobe), .cntZero(cntZero)
  );

  assign suspended = strobe.suspOn;
endmodule

// File: tb/tb_txsusp_ctrl.sv
module tb_txsusp_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swRst = 1'b0, dmaRst = 1'b0, regWrEn = 1'b0, regAddr = 1'b0;
  logic [31:0] regWrData = '0, fifoData = '0;
  logic        stopReq = 1'b0, dmaEn = 1'b0, blockDone = 1'b0, txTake = 1'b0, fifoValid = 1'b0;
  logic [31:0] regRdData, txData;
  logic        fifoReady, txValid, suspended;

  int compared = 0, mismatched = 0;
  string curReq = "R1";
  bit done = 1'b0;

  // reference model state
  int unsigned mProg = 0, mLive = 0;
  int          mState = 0;  // 0 idle, 1 draining, 2 suspended
  logic [31:0] mSub = '0;
  bit          mStopQ = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  txsusp_ctrl dut (.*);

  always @(posedge clk) begin
    if (!rstN) begin
      mProg = 0; mLive = 0; mState = 0; mSub = '0; mStopQ = 1'b0;
    end else begin
      if (swRst) begin
        mProg = 0; mLive = 0; mSub = '0; mState = 0;
      end else begin
        bit rise;
        int unsigned oldProg;
        rise = stopReq && !mStopQ;
        oldProg = mProg;
        if (dmaRst) mSub = '0;
        else if (regWrEn && regAddr && !dmaEn) mSub = regWrData;
        if (regWrEn && !regAddr) mProg = regWrData;
        case (mState)
          0: if (rise) begin mState = 1; mLive = oldProg; end
             else if (regWrEn && !regAddr) mLive = regWrData;
          1: if (!stopReq) mState = 0;
             else if (blockDone) begin
               if (mLive == 0) mState = 2; else mLive = mLive - 1;
             end
          default: if (blockDone && !stopReq) mState = 0;
        endcase
      end
      mStopQ = stopReq;
    end
  end

  always @(posedge clk) begin
    #5;
    if (rstN) begin
      bit          eS, eR, eV;
      logic [31:0] eT, eD;
      eS = (mState == 2);
      eR = txTake && !eS;
      eT = eS ? mSub : fifoData;
      eV = eS ? 1'b1 : fifoValid;
      eD = regAddr ? mSub : mLive;
      compared++;
      if (suspended !== eS || fifoReady !== eR || txData !== eT || txValid !== eV || regRdData !== eD) begin
        mismatched++;
        $display("FAIL %s model: susp=%0b rdy=%0b tx=%h vld=%0b rd=%h exp susp=%0b rdy=%0b tx=%h vld=%0b rd=%h",
                 curReq, suspended, fifoReady, txData, txValid, regRdData, eS, eR, eT, eV, eD);
      end
    end
  end

  task automatic settle();
    @(posedge clk); #5;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input string req, input logic a, input logic [31:0] exp);
    @(negedge clk); regAddr = a;
    settle();
    chk(req, regRdData, exp);
  endtask

  task automatic blk();
    @(negedge clk); blockDone = 1'b1;
    @(negedge clk); blockDone = 1'b0;
  endtask

  task automatic setStop(input logic v);
    @(negedge clk); stopReq = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    fifoData = 32'h1111_2222; fifoValid = 1'b1; txTake = 1'b1;
    curReq = "R1";
    rd("R1", 1'b0, 32'h0);
    rd("R1", 1'b1, 32'h0);
    chk("R1", {31'b0, suspended}, 32'h0);
    chk("R1", txData, 32'h1111_2222);

    curReq = "R2";
    wr(1'b0, 32'd3);
    rd("R2", 1'b0, 32'd3);
    wr(1'b1, 32'hA5A5_0001);
    rd("R2", 1'b1, 32'hA5A5_0001);

    curReq = "R9";
    @(negedge clk); dmaEn = 1'b1;
    wr(1'b1, 32'hDEAD_BEEF);
    rd("R9", 1'b1, 32'hA5A5_0001);

    curReq = "R3";
    setStop(1'b1);
    rd("R3", 1'b0, 32'd3);
    blk(); rd("R3", 1'b0, 32'd2);
    blk(); rd("R3", 1'b0, 32'd1);
    blk(); rd("R3", 1'b0, 32'd0);
    chk("R4", {31'b0, suspended}, 32'h0);
    curReq = "R4";
    blk(); settle();
    chk("R4", {31'b0, suspended}, 32'h1);
    curReq = "R6";
    fifoData = 32'h3333_4444;
    settle();
    chk("R6", txData, 32'hA5A5_0001);
    chk("R6", {31'b0, fifoReady}, 32'h0);

    curReq = "R7";
    setStop(1'b0);
    repeat (3) settle();
    chk("R7", {31'b0, suspended}, 32'h1);
    blk(); settle();
    chk("R7", {31'b0, suspended}, 32'h0);
    chk("R7", txData, 32'h3333_4444);

    curReq = "R5";
    wr(1'b0, 32'd0);
    setStop(1'b1);
    settle();
    blk(); settle();
    chk("R5", {31'b0, suspended}, 32'h1);
    setStop(1'b0); blk();

    curReq = "R8";
    wr(1'b0, 32'd5);
    setStop(1'b1);
    blk(); blk();
    setStop(1'b0);
    blk(); settle();
    chk("R8", {31'b0, suspended}, 32'h0);
    rd("R8", 1'b0, 32'd3);

    curReq = "R11";
    wr(1'b0, 32'd1);
    setStop(1'b1);
    blk();
    wr(1'b0, 32'd7);
    rd("R11", 1'b0, 32'd0);
    blk(); settle();
    chk("R11", {31'b0, suspended}, 32'h1);

    curReq = "R10";
    @(negedge clk); dmaRst = 1'b1;
    @(negedge clk); dmaRst = 1'b0;
    rd("R10", 1'b1, 32'h0);
    chk("R10", {31'b0, suspended}, 32'h1);
    @(negedge clk); dmaEn = 1'b0;
    wr(1'b1, 32'h0BAD_F00D);
    @(negedge clk); swRst = 1'b1;
    @(negedge clk); swRst = 1'b0;
    settle();
    chk("R10", {31'b0, suspended}, 32'h0);
    rd("R10", 1'b1, 32'h0);
    rd("R10", 1'b0, 32'h0);
    setStop(1'b0);

    curReq = "R6";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (($urandom % 16) == 0) stopReq = ~stopReq;
      blockDone = (($urandom % 6) == 0);
      txTake    = $urandom;
      fifoValid = $urandom;
      fifoData  = $urandom;
      dmaEn     = $urandom;
      regAddr   = $urandom;
      regWrEn   = (($urandom % 10) == 0);
      regWrData = $urandom % 4;
    end
    @(negedge clk); regWrEn = 1'b0; blockDone = 1'b0;
    settle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule